// File: doc/BRIEF.md
# Triggered Sample FIFO Loader

This block sits after a filtered-envelope stage and collects 16-bit samples into an 8-word first-in first-out buffer. A 3-bit source-select field decides what makes each write happen: one of three timer event strobes, every sample-ready strobe, or a request bit set by software. Select codes 011, 100 and 101 are reserved and never write. The latest sample is held in a sample register that updates on every sample-ready strobe, whether or not the buffer is in use. That register is always visible on its own output.

The pushed word is always the value the sample register holds after the same clock edge. When sample-ready and a trigger arrive together, the new sample is the one stored. The read side is a valid/ready stream. `rd_valid_o` is high whenever the buffer is not empty. A word leaves on a clock edge where both valid and ready are high. Ready may be held high while valid is low; this has no effect and the read data keeps the last word removed. The write side has no back-pressure. A trigger that arrives while the buffer is full is dropped and sets a sticky overflow flag, which only reset clears.

Top module: `sample_fifo_loader`

## Requirements
- R1: The buffer holds up to 8 words of 16 bits and returns them in write order. `count_o` gives the number held, `empty_o` is high at count 0 and `full_o` is high at count 8. After reset the count is 0, `empty_o` is 1, and the read data and the overflow flag are 0.
- R2: With select 000, 001 or 010, a write happens on a clock edge where timer event bit 0, 1 or 2 respectively is high.
- R3: With select 011, 100 or 101, no write ever happens, whatever the strobes and the request bit do.
- R4: With select 110, every sample-ready strobe writes, and the stored word is the sample arriving with that strobe.
- R5: Writing 1 to the request bit (`sw_wr_i` high with `sw_wdata_i` = 1) sets it. Writing 0 has no effect. With select 111, a set bit writes the current sample on the next clock edge.
- R6: The request bit clears itself on the edge where select 111 acts on it, whether the write is stored or dropped. If the bit is set in the same cycle, the set wins. `sw_req_o` shows the bit. Under other selects the bit stays pending.
- R7: The sample register takes `sample_i` on every sample-ready strobe, under any select, and `sample_o` shows it.
- R8: A trigger that arrives while `full_o` is high is dropped, even if a read happens in the same cycle, and it sets `overflow_o`. `overflow_o` then stays 1 until reset.
- R9: A word is removed when `rd_valid_o` and `rd_ready_i` are both high. `rd_valid_o` equals not-empty. When the buffer is empty, `rd_data_o` shows the last word removed and a read request changes nothing.
- R10: Only the selected source causes a write. Strobes from sources that are not selected, whether alone or at the same time as the selected one, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_i | input | 16 | Filtered envelope sample |
| sample_rdy_i | input | 1 | Single-cycle strobe: new sample present |
| timer_evt_i | input | 3 | Single-cycle timer event strobes, bit n = timer n |
| src_sel_i | input | 3 | Write source select code |
| sw_wr_i | input | 1 | Write strobe for the software request bit |
| sw_wdata_i | input | 1 | Value written to the request bit |
| sw_req_o | output | 1 | Request bit readback |
| sample_o | output | 16 | Sample register, readable at any time |
| rd_valid_o | output | 1 | Buffer holds a word |
| rd_ready_i | input | 1 | Consumer accepts the head word |
| rd_data_o | output | 16 | Head word, or last word removed when empty |
| empty_o | output | 1 | Buffer empty |
| full_o | output | 1 | Buffer full |
| count_o | output | 4 | Number of words held |
| overflow_o | output | 1 | Sticky: a trigger was dropped while full |

## Verification
The assertions check the following on every cycle: reserved selects never change the count unless a read happens, a full buffer never grows, the overflow flag never falls, a request bit acted on under select 111 clears, and a read from an empty buffer leaves both the count and the data unchanged. Some properties can only be shown by the bench scenarios, with its behavioural model compared on every clock. These are: that the stored words come out in order and carry the right sample, especially the new sample when the strobe and the write coincide; that each timer select reacts only to its own strobe; and that a write while full is dropped even when a read happens in the same cycle.

// File: rtl/sfl_pkg.sv
package sfl_pkg;
  typedef enum logic [2:0] {
    SRC_TMR0 = 3'b000,
    SRC_TMR1 = 3'b001,
    SRC_TMR2 = 3'b010,
    SRC_RSV3 = 3'b011,
    SRC_RSV4 = 3'b100,
    SRC_RSV5 = 3'b101,
    SRC_CONT = 3'b110,
    SRC_SW   = 3'b111
  } src_sel_e;
endpackage

// File: rtl/sfl_trigger_mux.sv
module sfl_trigger_mux
  import sfl_pkg::*;
#(
  parameter int NUM_TIMERS = 3
) (
  input  logic [2:0]            sel_i,
  input  logic [NUM_TIMERS-1:0] timer_i,
  input  logic                  rdy_i,
  input  logic                  sw_i,
  output logic                  load_o,
  output logic                  sw_sel_o
);
  src_sel_e sel;
  assign sel = src_sel_e'(sel_i);

  always_comb begin
    load_o   = 1'b0;
    sw_sel_o = 1'b0;
    for (int i = 0; i < NUM_TIMERS; i++) begin
      if (sel_i == 3'(i)) load_o = timer_i[i];
    end
    case (sel)
      SRC_CONT: load_o = rdy_i;
      SRC_SW: begin
        load_o   = sw_i;
        sw_sel_o = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/sfl_sw_req.sv
module sfl_sw_req (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_i,
  input  logic wdata_i,
  input  logic consume_i,
  output logic req_o
);
  logic req_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                req_q <= 1'b0;
    else if (wr_i && wdata_i)  req_q <= 1'b1;
    else if (consume_i)        req_q <= 1'b0;
  end

  assign req_o = req_q;

  AST_SW_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && consume_i && !(wr_i && wdata_i)) |=> !req_q); // R6
  AST_SW_ZERO_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_q && !(wr_i && wdata_i)) |=> !req_q); // R5
endmodule

// File: rtl/sfl_fifo.sv
module sfl_fifo #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              rd_ready_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              empty_o,
  output logic              full_o,
  output logic [$clog2(DEPTH+1)-1:0] count_o,
  output logic              overflow_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_C  = AW'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic [CW-1:0]     count_q;
  logic [DATA_W-1:0] last_q;
  logic              ovf_q;
  logic              do_push, do_pop, full, empty;

  assign full    = (count_q == DEPTH_C);
  assign empty   = (count_q == '0);
  assign do_push = push_i && !full;
  assign do_pop  = rd_ready_i && !empty;

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count_q <= '0;
      last_q  <= '0;
      ovf_q   <= 1'b0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == LAST_C) ? '0 : wr_ptr + 1'b1;
      if (do_pop) begin
        rd_ptr <= (rd_ptr == LAST_C) ? '0 : rd_ptr + 1'b1;
        last_q <= mem[rd_ptr];
      end
      case ({do_push, do_pop})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: ;
      endcase
      if (push_i && full) ovf_q <= 1'b1;
    end
  end

  assign rd_valid_o = !empty;
  assign rd_data_o  = empty ? last_q : mem[rd_ptr];
  assign empty_o    = empty;
  assign full_o     = full;
  assign count_o    = count_q;
  assign overflow_o = ovf_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !rd_ready_i) |=> count_q == DEPTH_C); // R8
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q); // R8
  AST_EMPTY_READ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !push_i) |=> (count_q == '0) && $stable(rd_data_o)); // R9
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= DEPTH_C); // R1
endmodule

// File: rtl/sample_fifo_loader.sv
module sample_fifo_loader
  import sfl_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int DEPTH      = 8,
  parameter int NUM_TIMERS = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [DATA_W-1:0]     sample_i,
  input  logic                  sample_rdy_i,
  input  logic [NUM_TIMERS-1:0] timer_evt_i,
  input  logic [2:0]            src_sel_i,
  input  logic                  sw_wr_i,
  input  logic                  sw_wdata_i,
  output logic                  sw_req_o,
  output logic [DATA_W-1:0]     sample_o,
  output logic                  rd_valid_o,
  input  logic                  rd_ready_i,
  output logic [DATA_W-1:0]     rd_data_o,
  output logic                  empty_o,
  output logic                  full_o,
  output logic [$clog2(DEPTH+1)-1:0] count_o,
  output logic                  overflow_o
);
  logic [DATA_W-1:0] sample_q, sample_next;
  logic              load_req, sw_sel, sw_req;

  assign sample_next = sample_rdy_i ? sample_i : sample_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sample_q <= '0;
    else        sample_q <= sample_next;
  end
  assign sample_o = sample_q;

  sfl_trigger_mux #(.NUM_TIMERS(NUM_TIMERS)) u_mux (
    .sel_i    (src_sel_i),
    .timer_i  (timer_evt_i),
    .rdy_i    (sample_rdy_i),
    .sw_i     (sw_req),
    .load_o   (load_req),
    .sw_sel_o (sw_sel)
  );

  sfl_sw_req u_swreq (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_i      (sw_wr_i),
    .wdata_i   (sw_wdata_i),
    .consume_i (sw_sel && load_req),
    .req_o     (sw_req)
  );
  assign sw_req_o = sw_req;

  sfl_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_i      (load_req),
    .push_data_i (sample_next),
    .rd_ready_i  (rd_ready_i),
    .rd_valid_o  (rd_valid_o),
    .rd_data_o   (rd_data_o),
    .empty_o     (empty_o),
    .full_o      (full_o),
    .count_o     (count_o),
    .overflow_o  (overflow_o)
  );

  AST_RESERVED_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ((src_sel_i inside {SRC_RSV3, SRC_RSV4, SRC_RSV5}) && !(rd_valid_o && rd_ready_i))
      |=> count_o == $past(count_o)); // R3
  AST_SAMPLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_rdy_i |=> sample_o == $past(sample_o)); // R7
endmodule

// File: tb/sample_fifo_loader_tb.sv
module sample_fifo_loader_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] sample_i = '0;
  logic        sample_rdy_i = 1'b0;
  logic [2:0]  timer_evt_i = '0;
  logic [2:0]  src_sel_i = 3'b011;
  logic        sw_wr_i = 1'b0, sw_wdata_i = 1'b0;
  logic        rd_ready_i = 1'b0;
  logic        sw_req_o, rd_valid_o, empty_o, full_o, overflow_o;
  logic [15:0] sample_o, rd_data_o;
  logic [3:0]  count_o;

  sample_fifo_loader u_dut (.*);

  always #10 clk = ~clk;

  int errors = 0, checks = 0, cycles = 0;
  string cur_req = "R1";

  // behavioural reference
  logic [15:0] mq[$];
  logic [15:0] m_last = '0, m_samp = '0;
  bit          m_ovf = 0, m_sw = 0;

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      mq.delete(); m_last = '0; m_samp = '0; m_ovf = 0; m_sw = 0;
    end else begin
      logic [15:0] ns;
      bit trig, popn;
      ns = sample_rdy_i ? sample_i : m_samp;
      case (src_sel_i)
        3'd0, 3'd1, 3'd2: trig = timer_evt_i[src_sel_i];
        3'd6: trig = sample_rdy_i;
        3'd7: trig = m_sw;
        default: trig = 0;
      endcase
      popn = rd_ready_i && mq.size() > 0;
      if (trig && mq.size() == 8) m_ovf = 1;
      if (popn) m_last = mq.pop_front();
      if (trig && (mq.size() + (popn ? 1 : 0)) < 8) mq.push_back(ns);
      if (sw_wr_i && sw_wdata_i) m_sw = 1;
      else if (src_sel_i == 3'd7 && m_sw) m_sw = 0;
      m_samp = ns;
    end
  end

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk("count", 32'(count_o), 32'(mq.size()));
    chk("empty", 32'(empty_o), 32'(mq.size() == 0));
    chk("full", 32'(full_o), 32'(mq.size() == 8));
    chk("valid", 32'(rd_valid_o), 32'(mq.size() != 0));
    chk("rd_data", 32'(rd_data_o), 32'(mq.size() ? mq[0] : m_last));
    chk("overflow", 32'(overflow_o), 32'(m_ovf));
    chk("sw_req", 32'(sw_req_o), 32'(m_sw));
    chk("sample", 32'(sample_o), 32'(m_samp));
  end

  task automatic tick();
    @(posedge clk); #2;
    sample_rdy_i = 0; timer_evt_i = '0; sw_wr_i = 0; sw_wdata_i = 0;
  endtask

  task automatic strobe(logic rdy, logic [15:0] s, logic [2:0] tm);
    sample_rdy_i = rdy; sample_i = s; timer_evt_i = tm;
    tick();
  endtask

  task automatic drain();
    rd_ready_i = 1;
    repeat (10) tick();
    rd_ready_i = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    @(negedge clk);
    cur_req = "R1";
    chk("reset count", 32'(count_o), 0);
    chk("reset empty", 32'(empty_o), 1);
    chk("reset rd_data", 32'(rd_data_o), 0);
    chk("reset overflow", 32'(overflow_o), 0);
    @(posedge clk); #2;

    // R2 / R10: each timer select, with non-selected strobes ignored
    cur_req = "R2";
    for (int t = 0; t < 3; t++) begin
      src_sel_i = 3'(t);
      strobe(1, 16'h1000 + 16'(t), 3'b111 & ~(3'b1 << t)); // R10 others only
      strobe(0, 16'h0, 3'b1 << t);
      strobe(1, 16'h2000 + 16'(t), 3'b111);                // R10 coincident
    end
    @(negedge clk); chk("R2 timers count", 32'(count_o), 6);
    drain();

    // R3: reserved codes
    cur_req = "R3";
    for (int c = 3; c < 6; c++) begin
      src_sel_i = 3'(c);
      sw_wr_i = 1; sw_wdata_i = 1;
      strobe(1, 16'h3300 + 16'(c), 3'b111);
      strobe(1, 16'h3400, 3'b111);
    end
    @(negedge clk); chk("R3 reserved count", 32'(count_o), 0);
    // request bit stays pending under non-software select (R6)
    cur_req = "R6";
    chk("R6 pending", 32'(sw_req_o), 1);
    @(posedge clk); #2;
    src_sel_i = 3'd7; tick(); // pending bit consumed
    @(negedge clk); chk("R6 cleared", 32'(sw_req_o), 0);
    chk("R5 pending pushed", 32'(count_o), 1);
    drain();

    // R4: continuous mode stores the new sample
    cur_req = "R4";
    src_sel_i = 3'd6;
    strobe(1, 16'hA001, 0); strobe(0, 16'hFFFF, 3'b111); strobe(1, 16'hA002, 0);
    strobe(1, 16'hA003, 0);
    @(negedge clk); chk("R4 head", 32'(rd_data_o), 32'hA001);
    chk("R4 count", 32'(count_o), 3);
    @(posedge clk); #2;
    // R9: drain, then read from empty
    cur_req = "R9";
    drain();
    @(negedge clk); chk("R9 last data", 32'(rd_data_o), 32'hA003);
    @(posedge clk); #2;

    // R5: software bit
    cur_req = "R5";
    src_sel_i = 3'd7;
    sw_wr_i = 1; sw_wdata_i = 0; tick();
    tick();
    @(negedge clk); chk("R5 write0 no effect", 32'(count_o), 0);
    @(posedge clk); #2;
    sample_rdy_i = 1; sample_i = 16'h5A5A; sw_wr_i = 1; sw_wdata_i = 1; tick();
    @(negedge clk); chk("R5 set", 32'(sw_req_o), 1);
    @(posedge clk); #2;
    @(negedge clk);
    cur_req = "R6";
    chk("R6 self clear", 32'(sw_req_o), 0);
    chk("R5 pushed word", 32'(rd_data_o), 32'h5A5A);
    @(posedge clk); #2;
    drain();

    // R8: fill, overflow, push with pop while full
    cur_req = "R8";
    src_sel_i = 3'd6;
    for (int i = 0; i < 8; i++) strobe(1, 16'hB000 + 16'(i), 0);
    @(negedge clk); chk("R8 full", 32'(full_o), 1);
    @(posedge clk); #2;
    strobe(1, 16'hBEEF, 0);
    rd_ready_i = 1; strobe(1, 16'hCAFE, 0); rd_ready_i = 0;
    @(negedge clk); chk("R8 overflow", 32'(overflow_o), 1);
    chk("R8 count after pop", 32'(count_o), 7);
    @(posedge clk); #2;
    // software request dropped while full still clears
    strobe(1, 16'hC001, 0);
    src_sel_i = 3'd7; sw_wr_i = 1; sw_wdata_i = 1; tick(); tick();
    drain();
    @(negedge clk); chk("R8 sticky", 32'(overflow_o), 1);
    @(posedge clk); #2;

    // R7: sample register under a reserved select
    cur_req = "R7";
    src_sel_i = 3'd4;
    strobe(1, 16'h7777, 0);
    @(negedge clk); chk("R7 sample", 32'(sample_o), 32'h7777);
    chk("R7 no load", 32'(count_o), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    errors++; checks++;
    $display("FAIL watchdog actual=%0d expected<20000", cycles);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule